// File: doc/BRIEF.md
# Four-State Bus Cycle Timing Generator

This block sets the state and bus-cycle rhythm of a small 4-bit-class controller core. It is driven by a single input clock. Every half period of that clock is one state. Four states in a row, T1, T2, T3 and T4, form one bus cycle. A bus cycle therefore lasts two input clock periods, and it is the unit in which instruction execution is counted.

The block needs no dual-edge flip-flops. One register chain advances on the rising edge and picks the clock period, first or second, within the bus cycle. The level of the clock then picks the half within that period. T1 and T2 fall in the first period, and T3 and T4 fall in the second.

Two phase outputs mark the states for the rest of the core:

- The primary phase is high during T1 and T2.
- The secondary phase is the primary phase delayed by one state, so it is high during T2 and T3. The two phases are therefore in quadrature.

Downstream sequencing can also use two further outputs:

- A one-hot state vector.
- A strobe that is high for the whole clock period that contains T1.

Top module: `bus_phase_gen`

## Requirements
- R1: Each state lasts half an input clock period. After the rising edge that ends reset, the states run in the order T1 (clock high), T2 (clock low), T3 (clock high), T4 (clock low). `tstate` bit 0 marks T1, bit 1 marks T2, bit 2 marks T3 and bit 3 marks T4.
- R2: After T4 the sequence wraps to T1, so a bus cycle is exactly four states, which is two clock periods. The order holds over any number of bus cycles.
- R3: `phk` is high during T1 and T2 and low during T3 and T4. It changes once per half bus cycle, at the start of T1 and at the start of T3.
- R4: `phl` equals `phk` delayed by one state, so it is high during T2 and T3 and low during T4 and T1. This places it in quadrature with `phk`.
- R5: `cyc_start` is high for exactly the one clock period that contains T1 and T2, and it is low for the clock period that contains T3 and T4.
- R6: A synchronous reset, sampled on the rising edge, forces `tstate` to T1 and drives `phk`, `phl` and `cyc_start` low for as long as reset is held. After release, the first state is T1. A reset applied in the middle of a bus cycle restarts the sequence from T1.
- R7: Exactly one bit of `tstate` is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; each half period is one state |
| rst | input | 1 | Synchronous reset, active high |
| phk | output | 1 | Primary phase, high during T1 and T2 |
| phl | output | 1 | Secondary phase, one state behind `phk` |
| tstate | output | 4 | One-hot state, bit 0 = T1 through bit 3 = T4 |
| cyc_start | output | 1 | High for the clock period containing T1 |

## Verification
Some properties are checked on every edge by assertions:

- The primary phase toggles every clock period while running.
- At each rising edge the secondary phase equals the primary phase.
- At each falling edge the secondary phase is the complement of the primary phase, which expresses the quadrature relation.
- The state vector is one-hot.
- While the strobe is high, the clock-high half is T1.

Other behaviour can only be shown by the bench scenarios, which compare every half period against an independently computed schedule:

- The exact T1 to T4 order and its wrap over many bus cycles.
- The reset values.
- The restart from T1 after a reset in the middle of a bus cycle.

// File: rtl/bus_phase_gen.sv
module bus_phase_gen (
  input  logic       clk,
  input  logic       rst,
  output logic       phk,
  output logic       phl,
  output logic [3:0] tstate,
  output logic       cyc_start
);

  logic live_q;
  logic half_q;
  logic phl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      half_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
      half_q <= live_q & ~half_q;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) phl_q <= 1'b0;
    else     phl_q <= phk;
  end

  assign phk       = live_q & ~half_q;
  assign phl       = phl_q;
  assign cyc_start = live_q & ~half_q;

  assign tstate[0] = ~live_q | (~half_q & clk);
  assign tstate[1] = live_q & ~half_q & ~clk;
  assign tstate[2] = live_q &  half_q &  clk;
  assign tstate[3] = live_q &  half_q & ~clk;

  a_r3_phk_toggles: assert property (@(posedge clk) disable iff (rst)
    live_q |=> (phk != $past(phk)));

  a_r4_phl_matches_at_rise: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (phl == phk));

  a_r4_phl_quadrature_at_fall: assert property (@(negedge clk) disable iff (rst)
    live_q |-> (phl != phk));

  a_r7_state_onehot: assert property (@(negedge clk) disable iff (rst)
    $countones(tstate) == 1);

  a_r5_strobe_in_t1: assert property (@(negedge clk) disable iff (rst)
    cyc_start |-> (tstate == 4'b0001));

endmodule

// File: tb/bus_phase_gen_tb.sv
module bus_phase_gen_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       phk, phl, cyc_start;
  logic [3:0] tstate;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  typedef struct packed {
    logic [3:0] st;
    logic       pk;
    logic       pl;
    logic       cs;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  bus_phase_gen u_dut (
    .clk(clk), .rst(rst), .phk(phk), .phl(phl),
    .tstate(tstate), .cyc_start(cyc_start)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: expected half-period items from the requirements
  task automatic push_states(input int n);
    for (int h = 0; h < n; h++) begin
      exp_t e;
      int k = h % 4;
      e.st = 4'b0001 << k;
      e.pk = (k < 2);
      e.pl = (k == 1) || (k == 2);
      e.cs = (k < 2);
      exp_q.push_back(e);
    end
  endtask

  // monitor: one item per half period, sampled mid-half
  task automatic run_monitor();
    while (exp_q.size() > 0) begin
      exp_t e;
      if (clk) @(negedge clk); else @(posedge clk);
      #2.5;
      e = exp_q.pop_front();
      chk("R1/R2 state order", tstate, e.st);
      chk("R3 phk", {3'b0, phk}, {3'b0, e.pk});
      chk("R4 phl", {3'b0, phl}, {3'b0, e.pl});
      chk("R5 cyc_start", {3'b0, cyc_start}, {3'b0, e.cs});
      chk("R7 onehot", {3'b0, ($countones(tstate) == 1)}, 4'b0001);
    end
  endtask

  task automatic check_reset_state();
    @(posedge clk); @(negedge clk); #2.5;
    chk("R6 reset tstate low half", tstate, 4'b0001);
    chk("R6 reset phk", {3'b0, phk}, 4'b0);
    chk("R6 reset phl", {3'b0, phl}, 4'b0);
    chk("R6 reset cyc_start", {3'b0, cyc_start}, 4'b0);
    @(posedge clk); #2.5;
    chk("R6 reset tstate high half", tstate, 4'b0001);
  endtask

  task automatic release_reset();
    @(negedge clk); #1 rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    repeat (2) @(posedge clk);
    check_reset_state();
    // long run: order and wrap over many bus cycles
    release_reset();
    push_states(400);
    run_monitor();
    // reset in the middle of a bus cycle (during T3)
    @(posedge clk); #1;
    if (phk) begin @(posedge clk); #1; end
    rst = 1'b1;
    check_reset_state();
    release_reset();
    push_states(24);
    run_monitor();
    // reset held one clock only, then restart
    @(negedge clk); #1 rst = 1'b1;
    @(posedge clk); @(negedge clk); #1 rst = 1'b0;
    chk("R6 short reset phk", {3'b0, phk}, 4'b0);
    push_states(16);
    run_monitor();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule